// File: doc/BRIEF.md
# External Memory Bus Interface with Multiplexed Address/Data

This block lets an 8-bit core with a 16-bit address space reach off-chip code and data memory through two 8-bit port groups. Each external access takes one fixed machine cycle of twelve clocks. The low port first carries the low address byte, and an address latch strobe goes high so that an external latch can capture that byte. The same pins then carry the data byte. The high port holds the upper address byte for the whole access. Code fetches are strobed by an active-low program-store strobe. Data reads and writes use their own active-low read and write strobes.

The core hands over requests on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the first clock of an access until the access has finished. A core that sees `req_ready` low must hold its request fields steady until they are taken. The response is a one-clock `rsp_valid` pulse with no back-pressure. For reads and fetches it carries `rsp_rdata`.

An external-code select input, sampled when a fetch is accepted, decides whether a code fetch runs on the pins. When this select is high, the block does not touch the pins and answers the fetch on its own. When no bus access is running, both port groups are driven from the general-purpose output and enable inputs.

Top module: `xmem_bus_if`

## Requirements
- R1: After reset, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `rsp_valid` is 0, `req_ready` is 1, and both port groups follow their general-purpose inputs.
- R2: The clocks after an accepted bus request are numbered phase 0 to 11. `ale` is 1 in phases 0 and 1 only. The low port drives address bits 7:0 with its enable set in phases 0, 1 and 2.
- R3: The high port drives address bits 15:8 with its enable set in every phase 0 to 11.
- R4: A code fetch accepted with `ext_code_n` = 0 drives `psen_n` low in phases 3 to 9, while `rd_n` and `wr_n` stay high. The low port enable is 0 in phases 3 to 11.
- R5: A data read (`req_code`=0, `req_we`=0) drives `rd_n` low in phases 3 to 9, while `psen_n` stays high. `rsp_rdata` equals the value on `lo_pin_in` during phase 9. A change of `lo_pin_in` in phase 10 has no effect on `rsp_rdata`.
- R6: A data write (`req_code`=0, `req_we`=1) drives `wr_n` low in phases 4 to 9. The low port drives the write byte with its enable set in phases 3 to 10, and its enable is 0 in phase 11.
- R7: `rsp_valid` is 1 for exactly one clock, in phase 11. `req_ready` is 0 in phases 0 to 11 and 1 in the clock after.
- R8: While idle, `lo_pin_out`/`lo_pin_oe` equal `gpio_lo_out`/`gpio_lo_oe`, and `hi_pin_out`/`hi_pin_oe` equal `gpio_hi_out`/`gpio_hi_oe`.
- R9: A code fetch accepted with `ext_code_n` = 1 causes no strobe and leaves the ports on their general-purpose values. `rsp_valid` pulses in the very next clock with `rsp_rdata` = 8'hFF, and `req_ready` is 1 again one clock later.
- R10: A `req_valid` raised while `req_ready` is 0 does not disturb the running access. The request is taken in the first clock in which `req_ready` returns, and that access starts in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 16 | Access address |
| req_we | input | 1 | 1 = data write, 0 = read |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Read or fetch byte |
| ext_code_n | input | 1 | 0 = code fetches go to the pins |
| gpio_lo_out | input | 8 | General-purpose value for the low port |
| gpio_lo_oe | input | 1 | General-purpose enable for the low port |
| gpio_hi_out | input | 8 | General-purpose value for the high port |
| gpio_hi_oe | input | 1 | General-purpose enable for the high port |
| lo_pin_in | input | 8 | Sensed low port pins |
| lo_pin_out | output | 8 | Low port drive value |
| lo_pin_oe | output | 1 | Low port output enable |
| hi_pin_out | output | 8 | High port drive value |
| hi_pin_oe | output | 1 | High port output enable |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Active-low code fetch strobe |
| rd_n | output | 1 | Active-low data read strobe |
| wr_n | output | 1 | Active-low data write strobe |

## Verification
The hardest case to reach is a request that arrives while an access is already running. The bench raises `req_valid` with a second address partway through a read and holds it there. It then checks that the high port still shows the first address and that nothing restarts. It also checks that the second access begins exactly one clock after `req_ready` returns. For the read sampling edge, the bench changes the low port input in phase 10. This shows that only the phase-9 value reaches `rsp_rdata`.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [1:0] {K_CODE, K_READ, K_WRITE} acc_kind_t;
  typedef enum logic [1:0] {S_IDLE, S_BUS, S_LOCAL} seq_state_t;
  localparam int ALE_PHASES  = 2;
  localparam int ADDR_HOLD   = 1;
  localparam int RD_FIRST    = 3;
  localparam int WR_FIRST    = 4;
endpackage

// File: rtl/xmem_sequencer.sv
module xmem_sequencer
  import xmem_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CYCLE_CLKS = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [2*DATA_W-1:0]   req_addr,
  input  logic                  req_we,
  input  logic                  req_code,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic                  ext_code_n,
  input  logic [DATA_W-1:0]     lo_pin_in,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  in_bus,
  output logic [$clog2(CYCLE_CLKS)-1:0] phase,
  output acc_kind_t             kind,
  output logic [2*DATA_W-1:0]   addr_q,
  output logic [DATA_W-1:0]     wdata_q
);
  localparam int PH_W = $clog2(CYCLE_CLKS);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(CYCLE_CLKS - 1);
  localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(CYCLE_CLKS - 3);

  seq_state_t state;
  logic       take;

  assign req_ready = (state == S_IDLE);
  assign take      = req_valid && req_ready;
  assign in_bus    = (state == S_BUS);
  assign rsp_valid = (state == S_LOCAL) || (in_bus && phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      phase     <= '0;
      kind      <= K_READ;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_rdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          phase   <= '0;
          kind    <= req_code ? K_CODE : (req_we ? K_WRITE : K_READ);
          if (req_code && ext_code_n) begin
            state     <= S_LOCAL;
            rsp_rdata <= '1;
          end else begin
            state <= S_BUS;
          end
        end
        S_BUS: begin
          if (phase == PH_SAMPLE && kind != K_WRITE) rsp_rdata <= lo_pin_in;
          if (phase == PH_LAST) state <= S_IDLE;
          else                  phase <= phase + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_no_take_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bus && phase != PH_LAST) |=> (in_bus && $stable(addr_q)));
  assert_ack_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

// File: rtl/xmem_strobe_gen.sv
module xmem_strobe_gen
  import xmem_pkg::*;
#(
  parameter int CYCLE_CLKS = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_bus,
  input  logic [$clog2(CYCLE_CLKS)-1:0] phase,
  input  acc_kind_t                     kind,
  output logic                          ale,
  output logic                          addr_drive,
  output logic                          wdata_drive,
  output logic                          psen_n,
  output logic                          rd_n,
  output logic                          wr_n
);
  localparam int PH_W = $clog2(CYCLE_CLKS);
  localparam logic [PH_W-1:0] PH_ALE_END  = PH_W'(ALE_PHASES);
  localparam logic [PH_W-1:0] PH_ADDR_END = PH_W'(ALE_PHASES + ADDR_HOLD);
  localparam logic [PH_W-1:0] PH_RD_FIRST = PH_W'(RD_FIRST);
  localparam logic [PH_W-1:0] PH_WR_FIRST = PH_W'(WR_FIRST);
  localparam logic [PH_W-1:0] PH_STB_LAST = PH_W'(CYCLE_CLKS - 3);
  localparam logic [PH_W-1:0] PH_WD_LAST  = PH_W'(CYCLE_CLKS - 2);

  logic rd_window, wr_window;

  always_comb begin
    rd_window   = in_bus && phase >= PH_RD_FIRST && phase <= PH_STB_LAST;
    wr_window   = in_bus && phase >= PH_WR_FIRST && phase <= PH_STB_LAST;
    ale         = in_bus && phase < PH_ALE_END;
    addr_drive  = in_bus && phase < PH_ADDR_END;
    wdata_drive = in_bus && kind == K_WRITE &&
                  phase >= PH_RD_FIRST && phase <= PH_WD_LAST;
    psen_n      = !(rd_window && kind == K_CODE);
    rd_n        = !(rd_window && kind == K_READ);
    wr_n        = !(wr_window && kind == K_WRITE);
  end

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n, ale}) <= 1);
  assert_wr_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n) |=> wdata_drive);
endmodule

// File: rtl/xmem_port_mux.sv
module xmem_port_mux #(
  parameter int DATA_W = 8
) (
  input  logic                in_bus,
  input  logic                addr_drive,
  input  logic                wdata_drive,
  input  logic [2*DATA_W-1:0] addr_q,
  input  logic [DATA_W-1:0]   wdata_q,
  input  logic [DATA_W-1:0]   gpio_lo_out,
  input  logic                gpio_lo_oe,
  input  logic [DATA_W-1:0]   gpio_hi_out,
  input  logic                gpio_hi_oe,
  output logic [DATA_W-1:0]   lo_pin_out,
  output logic                lo_pin_oe,
  output logic [DATA_W-1:0]   hi_pin_out,
  output logic                hi_pin_oe
);
  always_comb begin
    if (addr_drive)       lo_pin_out = addr_q[DATA_W-1:0];
    else if (wdata_drive) lo_pin_out = wdata_q;
    else if (in_bus)      lo_pin_out = '0;
    else                  lo_pin_out = gpio_lo_out;
    lo_pin_oe  = addr_drive || wdata_drive || (!in_bus && gpio_lo_oe);
    hi_pin_out = in_bus ? addr_q[2*DATA_W-1:DATA_W] : gpio_hi_out;
    hi_pin_oe  = in_bus || gpio_hi_oe;
  end
endmodule

// File: rtl/xmem_bus_if.sv
module xmem_bus_if
  import xmem_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CYCLE_CLKS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [2*DATA_W-1:0] req_addr,
  input  logic                req_we,
  input  logic                req_code,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic                ext_code_n,
  input  logic [DATA_W-1:0]   gpio_lo_out,
  input  logic                gpio_lo_oe,
  input  logic [DATA_W-1:0]   gpio_hi_out,
  input  logic                gpio_hi_oe,
  input  logic [DATA_W-1:0]   lo_pin_in,
  output logic [DATA_W-1:0]   lo_pin_out,
  output logic                lo_pin_oe,
  output logic [DATA_W-1:0]   hi_pin_out,
  output logic                hi_pin_oe,
  output logic                ale,
  output logic                psen_n,
  output logic                rd_n,
  output logic                wr_n
);
  localparam int PH_W = $clog2(CYCLE_CLKS);

  logic                in_bus, addr_drive, wdata_drive;
  logic [PH_W-1:0]     phase;
  acc_kind_t           kind;
  logic [2*DATA_W-1:0] addr_q;
  logic [DATA_W-1:0]   wdata_q;

  xmem_sequencer #(.DATA_W(DATA_W), .CYCLE_CLKS(CYCLE_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_code(req_code),
    .req_wdata(req_wdata), .ext_code_n(ext_code_n), .lo_pin_in(lo_pin_in),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .in_bus(in_bus),
    .phase(phase), .kind(kind), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  xmem_strobe_gen #(.CYCLE_CLKS(CYCLE_CLKS)) u_stb (
    .clk(clk), .rst_n(rst_n), .in_bus(in_bus), .phase(phase), .kind(kind),
    .ale(ale), .addr_drive(addr_drive), .wdata_drive(wdata_drive),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  xmem_port_mux #(.DATA_W(DATA_W)) u_mux (
    .in_bus(in_bus), .addr_drive(addr_drive), .wdata_drive(wdata_drive),
    .addr_q(addr_q), .wdata_q(wdata_q),
    .gpio_lo_out(gpio_lo_out), .gpio_lo_oe(gpio_lo_oe),
    .gpio_hi_out(gpio_hi_out), .gpio_hi_oe(gpio_hi_oe),
    .lo_pin_out(lo_pin_out), .lo_pin_oe(lo_pin_oe),
    .hi_pin_out(hi_pin_out), .hi_pin_oe(hi_pin_oe)
  );

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (lo_pin_oe && lo_pin_out == $past(lo_pin_out)));
  assert_read_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !lo_pin_oe);
  assert_ale_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (lo_pin_oe && hi_pin_oe));
endmodule

// File: tb/tb_xmem_bus_if.sv
module tb_xmem_bus_if;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_we, req_code;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, rsp_rdata;
  logic rsp_valid, ext_code_n;
  logic [7:0] gpio_lo_out, gpio_hi_out, lo_pin_in, lo_pin_out, hi_pin_out;
  logic gpio_lo_oe, gpio_hi_oe, lo_pin_oe, hi_pin_oe;
  logic ale, psen_n, rd_n, wr_n;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  xmem_bus_if dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_code(req_code),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ext_code_n(ext_code_n), .gpio_lo_out(gpio_lo_out), .gpio_lo_oe(gpio_lo_oe),
    .gpio_hi_out(gpio_hi_out), .gpio_hi_oe(gpio_hi_oe), .lo_pin_in(lo_pin_in),
    .lo_pin_out(lo_pin_out), .lo_pin_oe(lo_pin_oe), .hi_pin_out(hi_pin_out),
    .hi_pin_oe(hi_pin_oe), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_gpio(input string tag);
    chk(lo_pin_out == gpio_lo_out && lo_pin_oe == gpio_lo_oe, {tag, " lo gpio"},
        {lo_pin_oe, lo_pin_out}, {gpio_lo_oe, gpio_lo_out});
    chk(hi_pin_out == gpio_hi_out && hi_pin_oe == gpio_hi_oe, {tag, " hi gpio"},
        {hi_pin_oe, hi_pin_out}, {gpio_hi_oe, gpio_hi_out});
  endtask

  // kind: 0 code, 1 read, 2 write; assumes ext_code_n = 0 for fetches
  task automatic run_access(input int kind, input logic [15:0] a,
                            input logic [7:0] wd, input logic [7:0] rv);
    logic exp_ale, exp_psen, exp_rd, exp_wr, exp_oe;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_wdata = wd;
    req_code = (kind == 0); req_we = (kind == 2);
    for (int ph = 0; ph < 12; ph++) begin
      @(negedge clk);
      if (ph == 0) req_valid = 1'b0;
      lo_pin_in = (ph <= 9) ? rv : ~rv;
      exp_ale  = (ph < 2);
      exp_psen = !(kind == 0 && ph >= 3 && ph <= 9);
      exp_rd   = !(kind == 1 && ph >= 3 && ph <= 9);
      exp_wr   = !(kind == 2 && ph >= 4 && ph <= 9);
      exp_oe   = (ph < 3) || (kind == 2 && ph <= 10);
      chk(ale == exp_ale, $sformatf("R2 ale ph%0d", ph), ale, exp_ale);
      chk(lo_pin_oe == exp_oe, $sformatf("R4 R6 lo oe ph%0d", ph), lo_pin_oe, exp_oe);
      if (ph < 3)
        chk(lo_pin_out == a[7:0], $sformatf("R2 lo addr ph%0d", ph), lo_pin_out, a[7:0]);
      else if (exp_oe)
        chk(lo_pin_out == wd, $sformatf("R6 wdata ph%0d", ph), lo_pin_out, wd);
      chk(hi_pin_oe && hi_pin_out == a[15:8], $sformatf("R3 hi addr ph%0d", ph),
          hi_pin_out, a[15:8]);
      chk(psen_n == exp_psen, $sformatf("R4 psen_n ph%0d", ph), psen_n, exp_psen);
      chk(rd_n == exp_rd, $sformatf("R5 rd_n ph%0d", ph), rd_n, exp_rd);
      chk(wr_n == exp_wr, $sformatf("R6 wr_n ph%0d", ph), wr_n, exp_wr);
      chk(rsp_valid == (ph == 11), $sformatf("R7 rsp_valid ph%0d", ph), rsp_valid, ph == 11);
      chk(req_ready == 1'b0, $sformatf("R7 ready ph%0d", ph), req_ready, 0);
      if (ph == 11 && kind != 2)
        chk(rsp_rdata == rv, "R5 rdata", rsp_rdata, rv);
    end
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R7 ready after", req_ready, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 0; req_addr = 0; req_we = 0; req_code = 0;
    req_wdata = 0; ext_code_n = 0; lo_pin_in = 0;
    gpio_lo_out = 8'h5A; gpio_lo_oe = 1; gpio_hi_out = 8'hC3; gpio_hi_oe = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ale == 0 && psen_n && rd_n && wr_n, "R1 strobes idle",
        {ale, psen_n, rd_n, wr_n}, 4'b0111);
    chk(rsp_valid == 0 && req_ready == 1, "R1 handshake", {rsp_valid, req_ready}, 2'b01);
    chk_gpio("R1");
  endtask

  task automatic t_gpio();
    gpio_lo_out = 8'h3C; gpio_lo_oe = 0; gpio_hi_out = 8'h81; gpio_hi_oe = 1;
    @(negedge clk);
    chk_gpio("R8 pattern a");
    gpio_lo_out = 8'hF0; gpio_lo_oe = 1; gpio_hi_out = 8'h0F; gpio_hi_oe = 0;
    @(negedge clk);
    chk_gpio("R8 pattern b");
  endtask

  task automatic t_local_fetch();
    ext_code_n = 1'b1;
    @(negedge clk);
    req_valid = 1; req_code = 1; req_we = 0; req_addr = 16'h1234;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1 && rsp_rdata == 8'hFF, "R9 local ack",
        {rsp_valid, rsp_rdata}, 9'h1FF);
    chk(ale == 0 && psen_n && rd_n && wr_n, "R9 no strobes",
        {ale, psen_n, rd_n, wr_n}, 4'b0111);
    chk_gpio("R9");
    @(negedge clk);
    chk(rsp_valid == 0 && req_ready == 1, "R9 ready again",
        {rsp_valid, req_ready}, 2'b01);
    ext_code_n = 1'b0;
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    req_valid = 1; req_code = 0; req_we = 0; req_addr = 16'hA1B2;
    for (int ph = 0; ph < 12; ph++) begin
      @(negedge clk);
      if (ph == 0) req_valid = 0;
      if (ph == 4) begin
        req_valid = 1; req_addr = 16'h7E11; req_we = 1; req_wdata = 8'h99;
      end
      if (ph >= 5)
        chk(hi_pin_out == 8'hA1 && ready_low(), $sformatf("R10 first held ph%0d", ph),
            hi_pin_out, 8'hA1);
    end
    @(negedge clk);
    chk(req_ready == 1 && ale == 0, "R10 ready returns", {req_ready, ale}, 2'b10);
    @(negedge clk);
    req_valid = 0;
    chk(ale == 1 && hi_pin_out == 8'h7E && lo_pin_out == 8'h11, "R10 second starts",
        {ale, hi_pin_out, lo_pin_out}, {1'b1, 16'h7E11});
    repeat (11) @(negedge clk);
    @(negedge clk);
    chk(req_ready == 1, "R10 second done", req_ready, 1);
  endtask

  function automatic bit ready_low();
    return req_ready == 1'b0;
  endfunction

  initial begin
    t_reset();
    t_gpio();
    run_access(0, 16'h0F42, 8'h00, 8'hE7);
    run_access(1, 16'hFFFF, 8'h00, 8'h5C);
    run_access(2, 16'h8001, 8'hA5, 8'h00);
    run_access(1, 16'h0000, 8'h00, 8'h01);
    t_local_fetch();
    t_backpressure();
    t_gpio();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule